// File: doc/BRIEF.md
# Message-Signalled Interrupt Catcher

This block sits beside the inbound request path of a PCIe root port. Each inbound memory write is offered to it as an address and a data word. When the 64-bit address equals the doorbell address that software has programmed, the low bits of the data word select a vector. If that vector is enabled, the block latches a pending bit for it. The block drives a single level interrupt line. The line is high while any pending bit is set whose mask bit is clear.

Vectors come in banks of 32. Each bank has three 32-bit words: an enable word, a mask word and a pending word. Vector `v` lives in bank `v/32` at bit `v%32`. Software reaches all of these registers through a simple 32-bit register port. On that port a read returns data in the same cycle, and a write takes effect at the next clock edge. Pending bits are cleared by writing ones. An inbound write that lands in the same cycle as a clear of the same bit wins over the clear, so no interrupt is lost. The number of banks is a parameter, 8 by default, giving 256 vectors.

Top module: `msi_irq_catcher`

## Requirements
- R1: After a synchronous active-low reset, every register reads zero and `irq_out` is low.
- R2: The doorbell address is held in two read/write words. Offset 0x820 holds address bits 31:0 and offset 0x824 holds bits 63:32. Each reads back what was last written.
- R3: Bank `n` places its enable word at 0x828+12n, its mask word at 0x82C+12n and its pending word at 0x830+12n. Vector `v` maps to bank `v/32`, bit `v%32`.
- R4: An inbound write sets pending bit `v` at the next clock edge when all of these hold: it is valid, its address equals the programmed 64-bit doorbell address, and vector `v` is enabled. Here `v` is `msg_data[7:0]` in the default configuration, and all higher data bits are ignored.
- R5: No pending bit changes on an inbound write whose address differs in either word, or whose vector is disabled.
- R6: A write to a pending word clears each bit written as one and keeps each bit written as zero. Such a write never sets a pending bit.
- R7: `irq_out` is the OR over all vectors of pending AND NOT mask. A masked vector still latches its pending bit, and that bit raises `irq_out` once it is unmasked.
- R8: When an inbound set and a software clear hit the same pending bit in the same cycle, the bit ends up set.
- R9: Reads at any offset outside R2/R3 (including offsets not word aligned) return zero, and writes there change no register.
- R10: Enable and mask words are plain read/write words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_off | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_off` (combinational) |
| msg_valid | input | 1 | Inbound memory write present this cycle |
| msg_addr | input | 64 | Inbound write address |
| msg_data | input | 32 | Inbound write data |
| irq_out | output | 1 | Combined interrupt level |

## Verification
The inbound writes are varied so that each test isolates one gate:
- A matching write to an enabled vector shows the basic set.
- The same address aimed at a disabled vector isolates the enable gate.
- Matching data with a wrong high word, and then a wrong low word, show that both halves of the comparison matter.
- Data with junk in the upper bits addressing vector 255 checks that only the index bits are used and that the last bank decodes.
- A middle bank exercises the 12-byte stride.

On the software side, the pending-word writes test all-zero, single-bit and all-ones patterns, the last against an empty bank. A set and a clear of the same bit in one cycle separates set-wins from clear-wins. A behavioural model in the bench tracks the interrupt line on every clock across masking and unmasking.

// File: rtl/msi_rx_pkg.sv
// Package: shared widths and word type for the interrupt catcher.
// Assumes 32-bit register words and 32 vectors per bank.
package msi_rx_pkg;
    localparam int WORD_W      = 32;
    localparam int VEC_PER_GRP = 32;
    localparam int POS_W       = 5;
    localparam int MSG_ADDR_W  = 64;
    typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/msi_addr_match.sv
// Module: msi_addr_match
// Compares an inbound write address with the programmed doorbell address
// and extracts the vector index from the low data bits.
// Assumes: purely combinational; the caller registers the result.
module msi_addr_match
    import msi_rx_pkg::*;
#(
    parameter int VEC_W = 8
) (
    input  word_t                  tgt_lo,
    input  word_t                  tgt_hi,
    input  logic                   msg_valid,
    input  logic [MSG_ADDR_W-1:0]  msg_addr,
    input  word_t                  msg_data,
    output logic                   hit,
    output logic [VEC_W-1:0]       vec
);
    // Full 64-bit equality gated by the inbound valid.
    always_comb begin
        hit = msg_valid && (msg_addr == {tgt_hi, tgt_lo});
        vec = msg_data[VEC_W-1:0];
    end
endmodule

// File: rtl/msi_reg_decode.sv
// Module: msi_reg_decode
// Turns a register byte offset into one-hot selects for the address words
// and for each bank's enable, mask and pending words.
// Assumes: the parameterised offsets do not overlap; any other offset
// selects nothing.
module msi_reg_decode #(
    parameter int          NUM_GROUPS = 8,
    parameter int          OFF_W      = 12,
    parameter int unsigned LO_OFF     = 32'h820,
    parameter int unsigned HI_OFF     = 32'h824,
    parameter int unsigned BASE_OFF   = 32'h828,
    parameter int unsigned STRIDE     = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [OFF_W-1:0]      off,
    output logic                  sel_lo,
    output logic                  sel_hi,
    output logic [NUM_GROUPS-1:0] sel_en,
    output logic [NUM_GROUPS-1:0] sel_mk,
    output logic [NUM_GROUPS-1:0] sel_st
);
    localparam logic [OFF_W-1:0] LO_A = OFF_W'(LO_OFF);
    localparam logic [OFF_W-1:0] HI_A = OFF_W'(HI_OFF);

    // Address-word selects.
    always_comb begin
        sel_lo = (off == LO_A);
        sel_hi = (off == HI_A);
    end

    // One exact-match comparator per bank field.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank_dec
        localparam logic [OFF_W-1:0] EN_A = OFF_W'(BASE_OFF + STRIDE * g);
        localparam logic [OFF_W-1:0] MK_A = OFF_W'(BASE_OFF + STRIDE * g + 4);
        localparam logic [OFF_W-1:0] ST_A = OFF_W'(BASE_OFF + STRIDE * g + 8);
        assign sel_en[g] = (off == EN_A);
        assign sel_mk[g] = (off == MK_A);
        assign sel_st[g] = (off == ST_A);
    end

    AST_ONE_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({sel_lo, sel_hi, sel_en, sel_mk, sel_st})); // R3
endmodule

// File: rtl/msi_vec_group.sv
// Module: msi_vec_group
// One bank of 32 vectors: enable, mask and pending words, with
// write-one-to-clear pending and inbound set that wins over a clear.
// Assumes: wr_* strobes are already qualified by the decoded offset.
module msi_vec_group
    import msi_rx_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_mk,
    input  logic             wr_clr,
    input  word_t            wdata,
    input  logic             set_req,
    input  logic [POS_W-1:0] set_pos,
    output word_t            en_q,
    output word_t            mk_q,
    output word_t            st_q,
    output logic             pending
);
    word_t set_mask;
    word_t clr_mask;

    // Build set and clear masks for this cycle.
    always_comb begin
        set_mask = set_req ? ((word_t'(1) << set_pos) & en_q) : '0;
        clr_mask = wr_clr ? wdata : '0;
    end

    // Enable and mask words: plain read/write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q <= '0;
            mk_q <= '0;
        end else begin
            if (wr_en) en_q <= wdata;
            if (wr_mk) mk_q <= wdata;
        end
    end

    // Pending word: clear first, then set, so the set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= (st_q & ~clr_mask) | set_mask;
    end

    // Bank contribution to the interrupt line.
    assign pending = |(st_q & ~mk_q);

    AST_SET_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((st_q & ~$past(st_q) & ~$past(en_q)) == '0)); // R5
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(set_req) && $past(en_q[set_pos]))
            |-> st_q[$past(set_pos)]); // R8
    AST_CLEAR_ONLY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(st_q) & ~st_q & ~$past(clr_mask)) == '0)); // R6
endmodule

// File: rtl/msi_irq_catcher.sv
// Module: msi_irq_catcher (top)
// Catches inbound doorbell writes, latches per-vector pending bits in
// banks of 32, and drives one combined interrupt level.
// Assumes: register reads are combinational; writes land on the next edge.
module msi_irq_catcher
    import msi_rx_pkg::*;
#(
    parameter int          NUM_GROUPS = 8,
    parameter int          OFF_W      = 12,
    parameter int unsigned LO_OFF     = 32'h820,
    parameter int unsigned HI_OFF     = 32'h824,
    parameter int unsigned BASE_OFF   = 32'h828,
    parameter int unsigned STRIDE     = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [11:0]      reg_off,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    input  logic             msg_valid,
    input  logic [63:0]      msg_addr,
    input  logic [31:0]      msg_data,
    output logic             irq_out
);
    localparam int GRP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1;
    localparam int VEC_W = POS_W + GRP_W;

    word_t tgt_lo, tgt_hi;
    logic  sel_lo, sel_hi;
    logic [NUM_GROUPS-1:0] sel_en, sel_mk, sel_st;
    logic  hit;
    logic [VEC_W-1:0] vec;
    word_t en_w [NUM_GROUPS];
    word_t mk_w [NUM_GROUPS];
    word_t st_w [NUM_GROUPS];
    logic [NUM_GROUPS-1:0] pend;
    logic [NUM_GROUPS-1:0] st_any;

    msi_reg_decode #(
        .NUM_GROUPS(NUM_GROUPS), .OFF_W(OFF_W), .LO_OFF(LO_OFF),
        .HI_OFF(HI_OFF), .BASE_OFF(BASE_OFF), .STRIDE(STRIDE)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .off(reg_off[OFF_W-1:0]),
        .sel_lo(sel_lo), .sel_hi(sel_hi),
        .sel_en(sel_en), .sel_mk(sel_mk), .sel_st(sel_st)
    );

    msi_addr_match #(.VEC_W(VEC_W)) u_match (
        .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data), .hit(hit), .vec(vec)
    );

    // Doorbell address words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_lo <= '0;
            tgt_hi <= '0;
        end else if (reg_wr) begin
            if (sel_lo) tgt_lo <= reg_wdata;
            if (sel_hi) tgt_hi <= reg_wdata;
        end
    end

    // One bank per group; the set request is steered by the vector's group bits.
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_bank
        logic set_here;
        assign set_here = hit && (vec[VEC_W-1:POS_W] == GRP_W'(g));
        msi_vec_group u_grp (
            .clk(clk), .rst_n(rst_n),
            .wr_en(reg_wr && sel_en[g]),
            .wr_mk(reg_wr && sel_mk[g]),
            .wr_clr(reg_wr && sel_st[g]),
            .wdata(reg_wdata),
            .set_req(set_here), .set_pos(vec[POS_W-1:0]),
            .en_q(en_w[g]), .mk_q(mk_w[g]), .st_q(st_w[g]),
            .pending(pend[g])
        );
        assign st_any[g] = |st_w[g];
    end

    // Read-back mux: OR of selected words; unmatched offsets give zero.
    always_comb begin
        reg_rdata = '0;
        if (sel_lo) reg_rdata |= tgt_lo;
        if (sel_hi) reg_rdata |= tgt_hi;
        for (int g = 0; g < NUM_GROUPS; g++) begin
            if (sel_en[g]) reg_rdata |= en_w[g];
            if (sel_mk[g]) reg_rdata |= mk_w[g];
            if (sel_st[g]) reg_rdata |= st_w[g];
        end
    end

    // Combined interrupt level.
    assign irq_out = |pend;

    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> (|st_any)); // R7
    AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(hit) && !$past(reg_wr)) |-> $stable(st_any)); // R5
endmodule

// File: tb/tb_msi_irq_catcher.sv
module tb_msi_irq_catcher;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_off = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        msg_valid = 1'b0;
    logic [63:0] msg_addr = '0;
    logic [31:0] msg_data = '0;
    logic        irq_out;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #10 clk = ~clk;

    msi_irq_catcher dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_off(reg_off),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .msg_valid(msg_valid),
        .msg_addr(msg_addr), .msg_data(msg_data), .irq_out(irq_out)
    );

    // Behavioural reference model.
    logic [31:0] m_lo, m_hi;
    logic [31:0] m_en [8];
    logic [31:0] m_mk [8];
    logic [31:0] m_st [8];

    always @(posedge clk) begin
        bit match;
        int v;
        match = msg_valid && (msg_addr == {m_hi, m_lo});
        v = int'(msg_data & 32'hFF);
        if (!rst_n) begin
            m_lo = 0; m_hi = 0;
            for (int g = 0; g < 8; g++) begin m_en[g] = 0; m_mk[g] = 0; m_st[g] = 0; end
        end else begin
            if (reg_wr) begin
                if (reg_off == 12'h820) m_lo = reg_wdata;
                if (reg_off == 12'h824) m_hi = reg_wdata;
                for (int g = 0; g < 8; g++) begin
                    if (int'(reg_off) == 'h828 + 12*g) m_en[g] = reg_wdata;
                    if (int'(reg_off) == 'h82C + 12*g) m_mk[g] = reg_wdata;
                    if (int'(reg_off) == 'h830 + 12*g) m_st[g] = m_st[g] & ~reg_wdata;
                end
            end
            if (match && m_en[v/32][v%32]) m_st[v/32][v%32] = 1'b1;
        end
    end

    function automatic bit model_irq();
        for (int g = 0; g < 8; g++) if ((m_st[g] & ~m_mk[g]) != 0) return 1;
        return 0;
    endfunction

    task automatic chk32(input logic [31:0] act, input logic [31:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // R7: interrupt line compared with the model on every clock.
    always @(negedge clk) begin
        if (rst_n && !done) chk32({31'b0, irq_out}, {31'b0, model_irq()}, "R7 irq vs model");
    end

    task automatic wr(input logic [11:0] off, input logic [31:0] d);
        @(negedge clk); reg_wr = 1; reg_off = off; reg_wdata = d;
        @(negedge clk); reg_wr = 0;
    endtask

    task automatic msg(input logic [63:0] a, input logic [31:0] d);
        @(negedge clk); msg_valid = 1; msg_addr = a; msg_data = d;
        @(negedge clk); msg_valid = 0;
    endtask

    task automatic rd_chk(input logic [11:0] off, input logic [31:0] exp, input string tag);
        @(negedge clk); reg_wr = 0; reg_off = off;
        #5 chk32(reg_rdata, exp, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    localparam logic [63:0] DB = 64'h0000_0001_FEE0_1000;

    initial begin
        #(20 * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset state
        rd_chk(12'h820, 32'h0, "R1 addr lo after reset");
        rd_chk(12'h828, 32'h0, "R1 enable0 after reset");
        rd_chk(12'h884, 32'h0, "R1 pending7 after reset");
        chk32({31'b0, irq_out}, 32'h0, "R1 irq after reset");
        // R2 address words
        wr(12'h820, DB[31:0]);
        wr(12'h824, DB[63:32]);
        rd_chk(12'h820, 32'hFEE0_1000, "R2 addr lo");
        rd_chk(12'h824, 32'h0000_0001, "R2 addr hi");
        // R10 enables
        wr(12'h828, 32'h0000_0005);
        wr(12'h87C, 32'h8000_0000);
        rd_chk(12'h828, 32'h0000_0005, "R10 enable0");
        rd_chk(12'h87C, 32'h8000_0000, "R10 enable7");
        // R4 basic set
        msg(DB, 32'h2);
        rd_chk(12'h830, 32'h0000_0004, "R4 vector 2 set");
        chk32({31'b0, irq_out}, 32'h1, "R7 irq high");
        // R5 disabled vector and address mismatches
        msg(DB, 32'h1);
        rd_chk(12'h830, 32'h0000_0004, "R5 disabled vector ignored");
        msg(DB ^ 64'h0000_0002_0000_0000, 32'h0);
        rd_chk(12'h830, 32'h0000_0004, "R5 high word mismatch ignored");
        msg(DB ^ 64'h0000_0000_0000_0010, 32'h0);
        rd_chk(12'h830, 32'h0000_0004, "R5 low word mismatch ignored");
        // R4/R3 vector 255 with junk upper data bits
        msg(DB, 32'h1234_56FF);
        rd_chk(12'h884, 32'h8000_0000, "R4 R3 vector 255 in bank 7");
        // R7 masking
        wr(12'h880, 32'h8000_0000);
        rd_chk(12'h880, 32'h8000_0000, "R10 mask7");
        wr(12'h830, 32'h0);
        rd_chk(12'h830, 32'h0000_0004, "R6 zero write keeps");
        wr(12'h830, 32'h4);
        rd_chk(12'h830, 32'h0, "R6 one clears");
        chk32({31'b0, irq_out}, 32'h0, "R7 masked vector silent");
        rd_chk(12'h884, 32'h8000_0000, "R7 masked vector still latched");
        wr(12'h880, 32'h0);
        chk32({31'b0, irq_out}, 32'h1, "R7 unmask raises irq");
        wr(12'h884, 32'h8000_0000);
        rd_chk(12'h884, 32'h0, "R6 clear vector 255");
        // R8 same-cycle set and clear
        @(negedge clk);
        reg_wr = 1; reg_off = 12'h830; reg_wdata = 32'h1;
        msg_valid = 1; msg_addr = DB; msg_data = 32'h0;
        @(negedge clk); reg_wr = 0; msg_valid = 0;
        rd_chk(12'h830, 32'h0000_0001, "R8 set wins over clear");
        wr(12'h830, 32'h1);
        rd_chk(12'h830, 32'h0, "R6 clear after race");
        // R3 middle bank stride
        wr(12'h84C, 32'h0001_0000);
        rd_chk(12'h84C, 32'h0001_0000, "R3 enable3");
        msg(DB, 32'h70);
        rd_chk(12'h854, 32'h0001_0000, "R3 vector 112 in bank 3");
        wr(12'h850, 32'h00FF_00FF);
        rd_chk(12'h850, 32'h00FF_00FF, "R10 mask3 readback");
        // R6 all-ones to empty pending word never sets
        wr(12'h83C, 32'hFFFF_FFFF);
        rd_chk(12'h83C, 32'h0, "R6 write never sets");
        // R9 unused offsets
        rd_chk(12'h888, 32'h0, "R9 past last bank");
        rd_chk(12'h81C, 32'h0, "R9 below address words");
        rd_chk(12'h822, 32'h0, "R9 unaligned");
        wr(12'h888, 32'hFFFF_FFFF);
        rd_chk(12'h888, 32'h0, "R9 write ignored read");
        rd_chk(12'h820, 32'hFEE0_1000, "R9 addr lo untouched");
        rd_chk(12'h854, 32'h0001_0000, "R9 pending3 untouched");
        repeat (2) @(negedge clk);
        finish_run();
    end
endmodule